// File: doc/BRIEF.md
# Free-Running Timer with Time-Base Drive

The block is a free-running up counter meant to serve as a shared time base for the timing channels around it. Each clock cycle it may advance by one. Whether it advances depends on the selected count source. That source is one of six prescaler tick inputs, or a synchronized edge on an asynchronous external pin. The active edge of the pin is programmable, so the pin can count events or supply a clock that does not come from the system clock. A wrap from all ones to zero sets an overflow flag, which can raise an interrupt.

Software works through a small register port. It uses that port to pick the count source, the pin polarity and the overflow interrupt enable. The same port reads and clears the overflow flag, and reads or loads the count. A two-bit field routes the count onto one of two shared time-base buses, each with its own drive-enable flag, or onto neither.

Top module: `fr_timebase`

## Requirements
- R1: After reset the count is 0, the control register reads 0x0007 (source 7, stopped), the overflow flag is 0, neither bus is driven and `irq_o` is 0.
- R2: With source field (control bits [2:0]) set to k in 0..5, the count increases by exactly one for each cycle in which `tick_i[k]` is high, and pulses on the other tick inputs have no effect.
- R3: With source 6, the external pin passes through a two-flop synchronizer and each detected edge adds one. Control bit [3] = 0 counts rising edges and = 1 counts falling edges; the other edge has no effect.
- R4: With source 7 the count holds whatever the tick inputs and the pin do.
- R5: When an advance takes the count from 0xFFFF to 0x0000, the overflow flag (status address 1, bit 0) becomes 1.
- R6: Writing status bit 0 = 1 clears the flag, and writing 0 leaves it unchanged. A wrap in the same cycle as a clearing write leaves the flag at 1.
- R7: A write to address 2 loads the count with the written value, and this load wins over an advance in the same cycle.
- R8: `irq_o` is 1 exactly when the overflow flag is 1 and the interrupt enable (control bit [6]) is 1.
- R9: The bus field (control bits [5:4]) set to 01 drives the count on bus A with `bus_a_drv_o` = 1. A setting of 10 does the same on bus B. Settings 00 and 11 drive neither. A bus that is not driven outputs 0.
- R10: Reads are combinational. Address 0 returns the control bits [6:0] with the upper bits 0, address 1 returns the flag in bit 0, address 2 returns the count, and address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| tick_i | input | 6 | Prescaler tick inputs, one cycle wide |
| ext_pin | input | 1 | Asynchronous external count input |
| bus_a_o | output | 16 | Time-base bus A value |
| bus_a_drv_o | output | 1 | Bus A drive enable |
| bus_b_o | output | 16 | Time-base bus B value |
| bus_b_drv_o | output | 1 | Bus B drive enable |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The hardest case to reach is a wrap that lands in the same cycle as a write that clears the flag. The stimulus first sets the flag through a real wrap. It then loads 0xFFFF and holds the selected tick high while it writes 1 to the status bit in the same cycle. The flag must stay set and the count must read zero. The external source is also hard to reach, because its three-cycle synchronizer delay is not seen directly. The bench therefore lets several cycles pass after each pin transition before it reads the count, and it checks both polarities so that the opposite edge is seen to be ignored.

// File: rtl/fr_timebase.sv
module fr_timebase #(
  parameter int W    = 16,
  parameter int NTAP = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    rdata,
  input  logic [NTAP-1:0] tick_i,
  input  logic            ext_pin,
  output logic [W-1:0]    bus_a_o,
  output logic            bus_a_drv_o,
  output logic [W-1:0]    bus_b_o,
  output logic            bus_b_drv_o,
  output logic            irq_o
);
  localparam int SELW = $clog2(NTAP + 2);
  localparam int CTLW = SELW + 4;
  localparam logic [SELW-1:0] SEL_EXT  = SELW'(NTAP);
  localparam logic [SELW-1:0] SEL_STOP = {SELW{1'b1}};

  logic [CTLW-1:0] ctrl_q;
  logic [W-1:0]    cnt_q;
  logic            ovf_q;
  logic [2:0]      sync_q;

  wire [SELW-1:0] src     = ctrl_q[SELW-1:0];
  wire            fall    = ctrl_q[SELW];
  wire [1:0]      bus_sel = ctrl_q[SELW+2:SELW+1];
  wire            irq_en  = ctrl_q[SELW+3];

  wire ext_edge = fall ? (sync_q[2] & ~sync_q[1]) : (sync_q[1] & ~sync_q[2]);

  logic adv;
  always_comb begin
    if (src < SEL_EXT)       adv = tick_i[src];
    else if (src == SEL_EXT) adv = ext_edge;
    else                     adv = 1'b0;
  end

  wire wr_ctrl = wr_en && addr == 2'd0;
  wire wr_stat = wr_en && addr == 2'd1;
  wire wr_cnt  = wr_en && addr == 2'd2;
  wire wrap    = adv && !wr_cnt && (cnt_q == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTLW'(SEL_STOP);
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], ext_pin};
      if (wr_ctrl) ctrl_q <= wdata[CTLW-1:0];
      if (wr_cnt)   cnt_q <= wdata;
      else if (adv) cnt_q <= cnt_q + 1'b1;
      ovf_q <= wrap | (ovf_q & ~(wr_stat & wdata[0]));
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = W'(ctrl_q);
      2'd1:    rdata = W'(ovf_q);
      2'd2:    rdata = cnt_q;
      default: rdata = '0;
    endcase
  end

  assign bus_a_drv_o = bus_sel == 2'b01;
  assign bus_b_drv_o = bus_sel == 2'b10;
  assign bus_a_o     = bus_a_drv_o ? cnt_q : '0;
  assign bus_b_o     = bus_b_drv_o ? cnt_q : '0;
  assign irq_o       = ovf_q & irq_en;
endmodule

// File: rtl/fr_timebase_chk.sv
module fr_timebase_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] cnt,
  input logic [2:0]   src,
  input logic         ovf,
  input logic         irq_o,
  input logic         bus_a_drv_o,
  input logic         bus_b_drv_o
);
  wire load = wr_en && addr == 2'd2;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  assert_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 3'd7 && !load) |=> $stable(cnt));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == {W{1'b1}} && !load) ##1 (cnt == '0) |-> ovf);

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(wdata));

  assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ovf);

  assert_onebus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_a_drv_o, bus_b_drv_o}));
endmodule

bind fr_timebase fr_timebase_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cnt(cnt_q), .src(3'(ctrl_q[SELW-1:0])), .ovf(ovf_q), .irq_o(irq_o),
  .bus_a_drv_o(bus_a_drv_o), .bus_b_drv_o(bus_b_drv_o)
);

// File: tb/sim_fr_timebase.sv
module sim_fr_timebase;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, wr_en = 0, ext_pin = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [5:0] tick_i = 0;
  logic [15:0] rdata, bus_a_o, bus_b_o;
  logic bus_a_drv_o, bus_b_drv_o, irq_o;
  int checks = 0, failures = 0;
  bit done = 0;

  int    exp_q[$];
  int    sel_q[$];
  string tag_q[$];
  event  ev;

  always #(PERIOD/2) clk = ~clk;

  fr_timebase u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick_i(tick_i), .ext_pin(ext_pin), .bus_a_o(bus_a_o),
    .bus_a_drv_o(bus_a_drv_o), .bus_b_o(bus_b_o), .bus_b_drv_o(bus_b_drv_o), .irq_o(irq_o));

  initial forever begin
    @(ev);
    while (exp_q.size() > 0) begin
      int e, s, act;
      string t;
      e = exp_q.pop_front(); s = sel_q.pop_front(); t = tag_q.pop_front();
      case (s)
        0, 1, 2, 3: act = rdata;
        4: act = bus_a_o;
        5: act = bus_a_drv_o;
        6: act = bus_b_o;
        7: act = bus_b_drv_o;
        default: act = irq_o;
      endcase
      checks++;
      if (act != e) begin
        failures++;
        $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", t, s, act, e);
      end
    end
  end

  task automatic expect_v(int s, int e, string t);
    @(negedge clk);
    if (s < 4) addr = 2'(s);
    #1;
    exp_q.push_back(e); sel_q.push_back(s); tag_q.push_back(t);
    ->ev;
    #1;
  endtask

  task automatic wr(int a, int d, logic [5:0] tk = 0);
    @(negedge clk);
    wr_en = 1; addr = 2'(a); wdata = 16'(d); tick_i = tk;
    @(negedge clk);
    wr_en = 0; tick_i = 0;
  endtask

  task automatic pulse(logic [5:0] tk, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = tk;
      @(negedge clk); tick_i = 0;
    end
  endtask

  task automatic pin(logic v);
    @(negedge clk); ext_pin = v;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_v(0, 16'h0007, "R1 ctrl");
    expect_v(1, 0, "R1 flag");
    expect_v(2, 0, "R1 count");
    expect_v(5, 0, "R1 busA drv");
    expect_v(7, 0, "R1 busB drv");
    expect_v(8, 0, "R1 irq");

    wr(0, 16'h0000);
    pulse(6'b000001, 3);
    expect_v(2, 3, "R2 tap0 counts");
    pulse(6'b111110, 2);
    expect_v(2, 3, "R2 other taps ignored");
    wr(0, 16'h0003);
    pulse(6'b001000, 2);
    expect_v(2, 5, "R2 tap3 counts");
    pulse(6'b110111, 1);
    expect_v(2, 5, "R2 tap3 others ignored");

    wr(0, 16'h0007);
    pulse(6'b111111, 3);
    pin(1); pin(0);
    expect_v(2, 5, "R4 stopped");

    wr(0, 16'h0006);
    pin(1);
    expect_v(2, 6, "R3 rising counted");
    pin(0);
    expect_v(2, 6, "R3 falling ignored");
    wr(0, 16'h000E);
    pin(1);
    expect_v(2, 6, "R3 rising ignored in falling mode");
    pin(0);
    expect_v(2, 7, "R3 falling counted");

    wr(0, 16'h0040);
    wr(2, 16'hFFFE);
    pulse(6'b000001, 1);
    expect_v(2, 16'hFFFF, "R5 before wrap");
    expect_v(1, 0, "R5 no flag yet");
    expect_v(8, 0, "R8 irq low");
    pulse(6'b000001, 1);
    expect_v(2, 0, "R5 wrapped");
    expect_v(1, 1, "R5 flag set");
    expect_v(8, 1, "R8 irq high");
    wr(0, 16'h0000);
    expect_v(8, 0, "R8 irq masked");
    wr(1, 0);
    expect_v(1, 1, "R6 write 0 keeps flag");
    wr(1, 1);
    expect_v(1, 0, "R6 write 1 clears");

    wr(2, 16'hFFFF);
    pulse(6'b000001, 1);
    expect_v(1, 1, "R6 flag set again");
    wr(2, 16'hFFFF);
    wr(1, 1, 6'b000001);
    expect_v(1, 1, "R6 wrap beats clear");
    expect_v(2, 0, "R6 count wrapped");

    wr(2, 16'h1234, 6'b000001);
    expect_v(2, 16'h1234, "R7 load beats advance");

    wr(0, 16'h0017);
    expect_v(5, 1, "R9 bus A drv");
    expect_v(4, 16'h1234, "R9 bus A value");
    expect_v(7, 0, "R9 bus B idle");
    expect_v(6, 0, "R9 bus B zero");
    wr(0, 16'h0027);
    expect_v(7, 1, "R9 bus B drv");
    expect_v(6, 16'h1234, "R9 bus B value");
    expect_v(5, 0, "R9 bus A idle");
    wr(0, 16'h0037);
    expect_v(5, 0, "R9 code 11 no A");
    expect_v(7, 0, "R9 code 11 no B");
    expect_v(0, 16'h0037, "R10 ctrl readback");
    wr(0, 16'hFFFF);
    expect_v(0, 16'h007F, "R10 upper ctrl bits zero");
    expect_v(3, 0, "R10 addr3 zero");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule